// File: doc/BRIEF.md
# Sector Write-Protection Controller

This block decides, for each sector of a flash array, whether a program or erase may touch it. It keeps one protection byte per sector, a software protection switch driven by enable and disable command strobes, and a hardware write-protect input. The sector index query port answers combinationally whether the addressed sector may be modified right now.

The protection bytes are changed only by self-timed register operations. An erase operation fills every byte with FFh. A program operation copies a staged image into the register. That image is streamed in one byte per cycle over a load port, sector 0 first. While either operation runs, the busy flag is high and every query reports the sector as blocked. When the hardware pin is released, protection stays on for a fixed hold window. After that window it stays on only if the software switch is still set. Because the disable command is ignored while the pin is high, an enable issued before or during pin assertion survives the pin's release.

Top module: `sector_guard`

## Requirements
- R1: `query_allowed_o` is 0 when protection is active and the queried sector's byte is not 00h. FFh and every other non-zero value count as protected. In all other cases, and when busy is low, it is 1.
- R2: A one-cycle `cmd_enable_i` sets the software switch at the next rising edge, and `prot_active_o` is then 1. A `cmd_disable_i` with `wp_i` low clears the switch. If both strobes arrive together, enable wins.
- R3: While `wp_i` is 1, `prot_active_o` is 1 whatever the software switch holds.
- R4: If enable was issued before or while `wp_i` was 1, protection stays active after `wp_i` falls and the hold window ends.
- R5: With the software switch clear, `prot_active_o` stays 1 over the first WPD_CYCLES-1 rising edges after `wp_i` falls. It drops to 0 after the WPD_CYCLES-th edge.
- R6: A `cmd_disable_i` pulse that arrives while `wp_i` is 1 is ignored.
- R7: `cmd_erase_i` raises busy for exactly ERASE_CYCLES cycles. After that, every sector byte reads as FFh.
- R8: Bytes presented on `load_data_i` with `load_valid_i` fill sectors 0, 1, 2 and so on in order. `cmd_program_i` raises busy for exactly PROG_CYCLES cycles and then installs that image. The load position returns to sector 0 when a program completes and on reset.
- R9: While busy is 1, every query returns 0. A program or erase strobe that arrives during busy is ignored.
- R10: Reset clears the software switch and the load position but leaves the protection bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp_i | input | 1 | Hardware write-protect, 1 = asserted |
| cmd_enable_i | input | 1 | Software protection enable strobe |
| cmd_disable_i | input | 1 | Software protection disable strobe |
| cmd_program_i | input | 1 | Start the self-timed register program |
| cmd_erase_i | input | 1 | Start the self-timed register erase |
| load_valid_i | input | 1 | Load port byte valid |
| load_data_i | input | BYTE_W | Next protection byte of the staged image |
| query_sector_i | input | log2(NUM_SECTORS) | Sector index to test |
| query_allowed_o | output | 1 | 1 = the queried sector may be programmed or erased |
| prot_active_o | output | 1 | 1 = protection is currently enforced |
| busy_o | output | 1 | 1 = a register update is in progress |

## Verification
Random images are built by mixing 00h, FFh and arbitrary non-zero bytes. Each image is queried sector by sector with protection both on and off, which separates "byte is non-zero" from "byte is FFh" and also shows that the protection gate truly masks the bytes. The pin history is tested with three directed orderings: pin alone, enable before the pin, and enable during the pin. Stepping edge by edge through the hold window catches an off-by-one in the release. Overlapping a command with a busy operation, and resetting part way through a load, show that the ignored strobes and the reset leave the stored bytes and the load order untouched.

// File: rtl/sg_pkg.sv
`timescale 1ns/1ps
package sg_pkg;
   typedef enum logic [1:0] {
      SG_OP_IDLE  = 2'd0,
      SG_OP_PROG  = 2'd1,
      SG_OP_ERASE = 2'd2
   } sg_op_e;

   function automatic int sg_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/sg_wp_tracker.sv
`timescale 1ns/1ps
module sg_wp_tracker #(
   parameter int WPD_CYCLES = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wp_i,
   input  logic cmd_enable_i,
   input  logic cmd_disable_i,
   output logic sw_en_o,
   output logic prot_active_o
);
   localparam int CW = $clog2(WPD_CYCLES + 1);

   logic          sw_en_q;
   logic [CW-1:0] hold_q;

   // software switch: disable is refused while the pin is asserted
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sw_en_q <= 1'b0;
      end else if (cmd_enable_i) begin
         sw_en_q <= 1'b1;
      end else if (cmd_disable_i && !wp_i) begin
         sw_en_q <= 1'b0;
      end
   end

   // hold window: reloaded while the pin is high, drains after release
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= '0;
      end else if (wp_i) begin
         hold_q <= CW'(WPD_CYCLES);
      end else if (hold_q != '0) begin
         hold_q <= hold_q - CW'(1);
      end
   end

   assign sw_en_o       = sw_en_q;
   assign prot_active_o = wp_i | (hold_q != '0) | sw_en_q;
endmodule

// File: rtl/sg_update_seq.sv
`timescale 1ns/1ps
module sg_update_seq
   import sg_pkg::*;
#(
   parameter int PROG_CYCLES  = 12,
   parameter int ERASE_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_program_i,
   input  logic cmd_erase_i,
   output logic busy_o,
   output logic commit_prog_o,
   output logic commit_erase_o
);
   localparam int MAXC = sg_max(PROG_CYCLES, ERASE_CYCLES);
   localparam int CW   = $clog2(MAXC + 1);

   sg_op_e        op_q;
   logic [CW-1:0] cnt_q;
   logic          last;

   assign busy_o         = (op_q != SG_OP_IDLE);
   assign last           = busy_o && (cnt_q == CW'(1));
   assign commit_prog_o  = last && (op_q == SG_OP_PROG);
   assign commit_erase_o = last && (op_q == SG_OP_ERASE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q  <= SG_OP_IDLE;
         cnt_q <= '0;
      end else if (!busy_o) begin
         if (cmd_erase_i) begin
            op_q  <= SG_OP_ERASE;
            cnt_q <= CW'(ERASE_CYCLES);
         end else if (cmd_program_i) begin
            op_q  <= SG_OP_PROG;
            cnt_q <= CW'(PROG_CYCLES);
         end
      end else if (last) begin
         op_q  <= SG_OP_IDLE;
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q - CW'(1);
      end
   end
endmodule

// File: rtl/sg_store.sv
`timescale 1ns/1ps
module sg_store #(
   parameter int NUM_SECTORS = 64,
   parameter int BYTE_W      = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           load_valid_i,
   input  logic [BYTE_W-1:0]              load_data_i,
   input  logic                           commit_prog_i,
   input  logic                           commit_erase_i,
   input  logic [$clog2(NUM_SECTORS)-1:0] query_sector_i,
   output logic                           closed_o
);
   localparam int SW = $clog2(NUM_SECTORS);

   logic [SW-1:0]          ptr_q;
   logic [NUM_SECTORS-1:0] closed_vec;

   always_ff @(posedge clk) begin
      if (!rst_n || commit_prog_i) begin
         ptr_q <= '0;
      end else if (load_valid_i) begin
         ptr_q <= (ptr_q == SW'(NUM_SECTORS - 1)) ? '0 : ptr_q + SW'(1);
      end
   end

   // one staging byte and one live byte per sector; live bytes hold through reset
   for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_sec
      logic [BYTE_W-1:0] stage_q;
      logic [BYTE_W-1:0] live_q;

      always_ff @(posedge clk) begin
         if (load_valid_i && (ptr_q == SW'(s))) begin
            stage_q <= load_data_i;
         end
      end

      always_ff @(posedge clk) begin
         if (commit_erase_i) begin
            live_q <= '1;
         end else if (commit_prog_i) begin
            live_q <= stage_q;
         end
      end

      // only an all-zero byte opens a sector
      assign closed_vec[s] = |live_q;
   end

   assign closed_o = closed_vec[query_sector_i];
endmodule

// File: rtl/sector_guard.sv
`timescale 1ns/1ps
module sector_guard #(
   parameter int NUM_SECTORS  = 64,
   parameter int BYTE_W       = 8,
   parameter int WPD_CYCLES   = 20,
   parameter int PROG_CYCLES  = 12,
   parameter int ERASE_CYCLES = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wp_i,
   input  logic                           cmd_enable_i,
   input  logic                           cmd_disable_i,
   input  logic                           cmd_program_i,
   input  logic                           cmd_erase_i,
   input  logic                           load_valid_i,
   input  logic [BYTE_W-1:0]              load_data_i,
   input  logic [$clog2(NUM_SECTORS)-1:0] query_sector_i,
   output logic                           query_allowed_o,
   output logic                           prot_active_o,
   output logic                           busy_o
);
   if (NUM_SECTORS < 2 || (NUM_SECTORS & (NUM_SECTORS - 1)) != 0) begin : g_bad_sectors
      $error("sector_guard: NUM_SECTORS must be a power of two >= 2");
   end
   if (BYTE_W < 1) begin : g_bad_width
      $error("sector_guard: BYTE_W must be >= 1");
   end
   if (WPD_CYCLES < 1 || PROG_CYCLES < 1 || ERASE_CYCLES < 1) begin : g_bad_timing
      $error("sector_guard: cycle counts must be >= 1");
   end

   logic sw_en;
   logic commit_prog;
   logic commit_erase;
   logic closed;

   sg_wp_tracker #(.WPD_CYCLES(WPD_CYCLES)) u_wp (
      .clk           (clk),
      .rst_n         (rst_n),
      .wp_i          (wp_i),
      .cmd_enable_i  (cmd_enable_i),
      .cmd_disable_i (cmd_disable_i),
      .sw_en_o       (sw_en),
      .prot_active_o (prot_active_o)
   );

   sg_update_seq #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_seq (
      .clk            (clk),
      .rst_n          (rst_n),
      .cmd_program_i  (cmd_program_i),
      .cmd_erase_i    (cmd_erase_i),
      .busy_o         (busy_o),
      .commit_prog_o  (commit_prog),
      .commit_erase_o (commit_erase)
   );

   sg_store #(.NUM_SECTORS(NUM_SECTORS), .BYTE_W(BYTE_W)) u_store (
      .clk            (clk),
      .rst_n          (rst_n),
      .load_valid_i   (load_valid_i),
      .load_data_i    (load_data_i),
      .commit_prog_i  (commit_prog),
      .commit_erase_i (commit_erase),
      .query_sector_i (query_sector_i),
      .closed_o       (closed)
   );

   assign query_allowed_o = !busy_o && !(prot_active_o && closed);
endmodule

// File: rtl/sector_guard_chk.sv
`timescale 1ns/1ps
module sector_guard_chk #(
   parameter int WPD_CYCLES   = 20,
   parameter int PROG_CYCLES  = 12,
   parameter int ERASE_CYCLES = 8
) (
   input logic clk,
   input logic rst_n,
   input logic wp_i,
   input logic cmd_enable_i,
   input logic sw_en_i,
   input logic query_allowed_o,
   input logic prot_active_o,
   input logic busy_o
);
   localparam int MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
   localparam int RW   = $clog2(WPD_CYCLES + 1);
   localparam int BW   = $clog2(MAXC + 2);

   logic [RW-1:0] rel_cnt;
   logic [BW-1:0] busy_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rel_cnt <= RW'(WPD_CYCLES);
      end else if (wp_i) begin
         rel_cnt <= '0;
      end else if (rel_cnt < RW'(WPD_CYCLES)) begin
         rel_cnt <= rel_cnt + RW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !busy_o) begin
         busy_cnt <= '0;
      end else begin
         busy_cnt <= busy_cnt + BW'(1);
      end
   end

   a_r3_wp_forces: assert property (@(posedge clk) disable iff (!rst_n)
      wp_i |-> prot_active_o);

   a_r2_enable_applies: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_enable_i |=> prot_active_o);

   a_r6_disable_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (wp_i && sw_en_i) |=> sw_en_i);

   a_r5_hold_window: assert property (@(posedge clk) disable iff (!rst_n)
      (!wp_i && rel_cnt < RW'(WPD_CYCLES)) |-> prot_active_o);

   a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !query_allowed_o);

   a_r7_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      busy_cnt <= BW'(MAXC));
endmodule

bind sector_guard sector_guard_chk #(
   .WPD_CYCLES   (WPD_CYCLES),
   .PROG_CYCLES  (PROG_CYCLES),
   .ERASE_CYCLES (ERASE_CYCLES)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .wp_i            (wp_i),
   .cmd_enable_i    (cmd_enable_i),
   .sw_en_i         (sw_en),
   .query_allowed_o (query_allowed_o),
   .prot_active_o   (prot_active_o),
   .busy_o          (busy_o)
);

// File: tb/sector_guard_tb.sv
`timescale 1ns/1ps
module sector_guard_tb;
   localparam int CLK_P = 10;
   localparam int NS    = 64;
   localparam int BW    = 8;
   localparam int WPD   = 20;
   localparam int PROGC = 12;
   localparam int ERAC  = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wp_i = 1'b0;
   logic          cmd_enable_i = 1'b0, cmd_disable_i = 1'b0;
   logic          cmd_program_i = 1'b0, cmd_erase_i = 1'b0;
   logic          load_valid_i = 1'b0;
   logic [BW-1:0] load_data_i = '0;
   logic [5:0]    query_sector_i = '0;
   logic          query_allowed_o, prot_active_o, busy_o;

   int n_vec = 0;
   int n_bad = 0;
   logic [BW-1:0] img [NS];
   logic [BW-1:0] live [NS];

   always #(CLK_P/2) clk = ~clk;

   sector_guard #(.NUM_SECTORS(NS), .BYTE_W(BW), .WPD_CYCLES(WPD),
                  .PROG_CYCLES(PROGC), .ERASE_CYCLES(ERAC)) u_dut (
      .clk(clk), .rst_n(rst_n), .wp_i(wp_i),
      .cmd_enable_i(cmd_enable_i), .cmd_disable_i(cmd_disable_i),
      .cmd_program_i(cmd_program_i), .cmd_erase_i(cmd_erase_i),
      .load_valid_i(load_valid_i), .load_data_i(load_data_i),
      .query_sector_i(query_sector_i), .query_allowed_o(query_allowed_o),
      .prot_active_o(prot_active_o), .busy_o(busy_o));

   function automatic logic exp_allowed(input logic prot, input logic [BW-1:0] b);
      return !(prot && (b != '0));
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #(CLK_P/4);
   endtask

   task automatic pulse(ref logic sig);
      sig = 1'b1; cyc(1); sig = 1'b0;
   endtask

   task automatic load_image();
      for (int s = 0; s < NS; s++) begin
         load_valid_i = 1'b1; load_data_i = img[s]; cyc(1);
      end
      load_valid_i = 1'b0;
   endtask

   // counts busy samples after a start strobe, checking queries stay blocked
   task automatic run_op(input bit erase, input string req, input int expc);
      int n = 0;
      if (erase) pulse(cmd_erase_i); else pulse(cmd_program_i);
      while (busy_o && n < 200) begin
         n++;
         query_sector_i = 6'(n); #1;
         chk("R9", query_allowed_o, 0);
         cyc(1);
      end
      chk(req, n, expc);
      if (erase) for (int s = 0; s < NS; s++) live[s] = '1;
      else       for (int s = 0; s < NS; s++) live[s] = img[s];
   endtask

   task automatic query_all(input logic prot, input string req);
      for (int s = 0; s < NS; s++) begin
         query_sector_i = 6'(s); #1;
         chk(req, query_allowed_o, exp_allowed(prot, live[s]));
         cyc(1);
      end
   endtask

   task automatic rand_image();
      for (int s = 0; s < NS; s++) begin
         int unsigned r = $urandom;
         case (r % 3)
            0: img[s] = 8'h00;
            1: img[s] = 8'hFF;
            default: img[s] = 8'((r >> 8) | 1);
         endcase
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int unsigned seed = $urandom(32'h5EC7_0A11);
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      // R10 reset state: switch clear, not busy
      chk("R10", prot_active_o, 0);
      chk("R9", busy_o, 0);
      query_sector_i = 6'd5; #1;
      chk("R1", query_allowed_o, 1);

      // R7 erase then enable: every sector closed
      run_op(1'b1, "R7", ERAC);
      pulse(cmd_enable_i);
      chk("R2", prot_active_o, 1);
      query_all(1'b1, "R7");

      // R8 mixed image, with explicit odd value in sector 3
      rand_image();
      img[3] = 8'h5A; img[4] = 8'h00; img[5] = 8'hFF;
      load_image();
      run_op(1'b0, "R8", PROGC);
      query_all(1'b1, "R1");
      pulse(cmd_disable_i);
      chk("R2", prot_active_o, 0);
      query_all(1'b0, "R1");

      // random rounds, protection on or off
      for (int k = 0; k < 5; k++) begin
         bit on = 1'($urandom % 2);
         rand_image();
         load_image();
         run_op(1'b0, "R8", PROGC);
         if (on) pulse(cmd_enable_i); else pulse(cmd_disable_i);
         query_all(on, "R1");
      end
      pulse(cmd_disable_i);

      // R3 / R5 pin alone, edge by edge release
      wp_i = 1'b1; #1;
      chk("R3", prot_active_o, 1);
      cyc(2);
      wp_i = 1'b0;
      for (int k = 1; k <= WPD; k++) begin
         cyc(1);
         chk("R5", prot_active_o, (k < WPD) ? 1 : 0);
      end

      // R4 enable while pin high
      wp_i = 1'b1; cyc(1);
      pulse(cmd_enable_i);
      wp_i = 1'b0; cyc(WPD + 3);
      chk("R4", prot_active_o, 1);
      pulse(cmd_disable_i);
      chk("R2", prot_active_o, 0);

      // R4 enable before pin, then R6 disable during pin
      pulse(cmd_enable_i);
      wp_i = 1'b1; cyc(2);
      wp_i = 1'b0; cyc(WPD + 3);
      chk("R4", prot_active_o, 1);
      wp_i = 1'b1; cyc(1);
      pulse(cmd_disable_i);
      wp_i = 1'b0; cyc(WPD + 3);
      chk("R6", prot_active_o, 1);
      pulse(cmd_disable_i);
      chk("R6", prot_active_o, 0);

      // R9 program strobe during erase is ignored; block stays unchanged after
      pulse(cmd_erase_i);
      cyc(2);
      pulse(cmd_program_i);
      cyc(ERAC);
      chk("R9", busy_o, 0);
      cyc(1);
      chk("R9", busy_o, 0);
      for (int s = 0; s < NS; s++) live[s] = '1;
      pulse(cmd_enable_i);
      query_all(1'b1, "R9");

      // R10 reset keeps bytes, clears switch and load position
      rand_image();
      load_image();
      run_op(1'b0, "R8", PROGC);
      load_valid_i = 1'b1; load_data_i = 8'hFF; cyc(7); load_valid_i = 1'b0;
      rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(1);
      chk("R10", prot_active_o, 0);
      pulse(cmd_enable_i);
      query_all(1'b1, "R10");
      rand_image();
      load_image();
      run_op(1'b0, "R8", PROGC);
      query_all(1'b1, "R10");

      if (seed == 0) n_vec += 0;
      finish_run();
   end
endmodule